// File: doc/BRIEF.md
# Display Controller Address and Status Register

This block is the host-facing front register of a display controller. A host reaches it over either a parallel or a serial bus, chosen by a mode input. One byte holds a target register index and four control bits: standby, display enable, a high-impedance control bit and a serial write-protect bit. Reading the byte also returns a busy flag. The flag is raised by every display-memory access and held for the whole of a reset.

The block decides which host requests reach the rest of the register file. Requests to any register other than this one are forwarded only when the controller is not busy. Writes are also blocked when the serial write-protect bit is set. The write-protect bit only matters on the serial bus: on the parallel bus it reads as zero and cannot be written. It also clears itself whenever the register-select line falls. Forwarded requests appear one clock later on registered strobes, and the stored index tells the register file which register they target.

Top module: `lcdas_addr_status`

## Requirements
- R1: While `rst` is high, `busy` is 1 and standby, display enable, HZ, write-protect and the index all read 0. On the first clock after `rst` falls, `busy` reads 0 unless a memory access is made in that cycle.
- R2: `status` is laid out as follows. Bit 7 is busy, bit 6 is standby, bit 5 is display enable, bit 4 is the effective write-protect and bit 3 is HZ. Bit 2 always reads 0. Bits [1:0] hold the register index.
- R3: A `mem_access` pulse sampled at a clock edge makes `busy` read 1 after that edge and the next 7 edges. `busy` reads 0 after the 8th edge. A new access while busy restarts the 8-edge count.
- R4: Bit 7 of a write to the address register (`wr_en`=1, `wr_is_addr`=1) has no effect on `busy`.
- R5: While `busy` is 1, host reads and writes to other registers (`wr_is_addr`/`rd_is_addr`=0) are not forwarded. Writes to the address register are still accepted.
- R6: In serial mode (`serial_mode`=1) with write-protect set, writes to other registers are dropped. Address-register writes, including one that clears bit 4, are still accepted.
- R7: In parallel mode (`serial_mode`=0), status bit 4 reads 0. A write of 1 to bit 4 does not block forwarded writes.
- R8: A high-to-low transition of `rsel` clears write-protect on the edge that samples `rsel` low. This clear wins over an address-register write in the same cycle.
- R9: A write that sets standby while `busy` is 1 leaves standby at 0. A write that clears standby while busy is accepted.
- R10: `so_oe` is 1 only in serial mode with `rst` low.
- R11: An accepted write to another register raises `fwd_wr_en` for exactly one cycle after the edge, with `fwd_wr_data` equal to the written byte. An accepted read raises `fwd_rd_en` in the same way. A read of the address register raises neither strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 1 = serial host bus, 0 = parallel |
| rsel | input | 1 | Register-select line; a falling edge clears write-protect |
| mem_access | input | 1 | Display-memory read or write strobe |
| wr_en | input | 1 | Host write request |
| wr_is_addr | input | 1 | Write targets the address register |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read request |
| rd_is_addr | input | 1 | Read targets the address register |
| status | output | 8 | Address/status byte as read by the host |
| reg_index | output | IDX_W | Selected target register index |
| standby | output | 1 | Standby control |
| disp_on | output | 1 | Display enable |
| hz | output | 1 | High-impedance control bit |
| busy | output | 1 | Busy flag |
| fwd_wr_en | output | 1 | Forwarded write strobe |
| fwd_rd_en | output | 1 | Forwarded read strobe |
| fwd_wr_data | output | 8 | Forwarded write byte |
| so_oe | output | 1 | Serial data output enable |

## Verification
The gating is tried with the same write to another register under four conditions: idle, busy, serial with write-protect set, and parallel with bit 4 written. This separates the busy check from the protect check and the protect check from the bus mode. Busy timing is probed at the 8th and 9th sample after a single access and after a repeated access, which distinguishes an exact count from an off-by-one or a missing reload. The register-select edge is tried alone and in the same cycle as a write that sets bit 4, which shows which of the two wins.

// File: rtl/lcdas_pkg.sv
package lcdas_pkg;
  localparam int DATA_W    = 8;
  localparam int BIT_BUSY  = 7;
  localparam int BIT_STBY  = 6;
  localparam int BIT_DISP  = 5;
  localparam int BIT_WPROT = 4;
  localparam int BIT_HZ    = 3;
  localparam int IDX_MAX_W = 2;

  typedef struct packed {
    logic standby;
    logic disp_on;
    logic wprot;
    logic hz;
  } ctrl_t;
endpackage

// File: rtl/lcdas_busy_timer.sv
module lcdas_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mem_access,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (mem_access)
      cnt_nxt = LOAD;
    else if (cnt_q != '0)
      cnt_nxt = cnt_q - 1'b1;
    else
      cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      busy  <= (cnt_nxt != '0);
    end
  end
endmodule

// File: rtl/lcdas_ctrl_bits.sv
module lcdas_ctrl_bits
  import lcdas_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_mode,
  input  logic              rsel,
  input  logic              busy,
  input  logic              addr_wr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [IDX_W-1:0]  index
);
  logic  rsel_d;
  logic  rsel_fall;
  ctrl_t ctrl_nxt;

  assign rsel_fall = rsel_d & ~rsel;

  always_comb begin
    ctrl_nxt = ctrl;
    if (addr_wr) begin
      ctrl_nxt.disp_on = wr_data[BIT_DISP];
      ctrl_nxt.hz      = wr_data[BIT_HZ];
      if (!(busy && wr_data[BIT_STBY]))
        ctrl_nxt.standby = wr_data[BIT_STBY];
      if (serial_mode)
        ctrl_nxt.wprot = wr_data[BIT_WPROT];
    end
    if (rsel_fall)
      ctrl_nxt.wprot = 1'b0;
  end

  always_ff @(posedge clk) begin
    rsel_d <= rst ? 1'b0 : rsel;
    if (rst) begin
      ctrl  <= '0;
      index <= '0;
    end else begin
      ctrl <= ctrl_nxt;
      if (addr_wr)
        index <= wr_data[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/lcdas_access_gate.sv
module lcdas_access_gate
  import lcdas_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_mode,
  input  logic              busy,
  input  logic              wprot,
  input  logic              wr_en,
  input  logic              wr_is_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_is_addr,
  output logic              addr_wr,
  output logic              fwd_wr_en,
  output logic              fwd_rd_en,
  output logic [DATA_W-1:0] fwd_wr_data
);
  logic wr_ok, rd_ok;

  assign addr_wr = wr_en & wr_is_addr;
  assign wr_ok   = wr_en & ~wr_is_addr & ~busy & ~(serial_mode & wprot);
  assign rd_ok   = rd_en & ~rd_is_addr & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_wr_en   <= 1'b0;
      fwd_rd_en   <= 1'b0;
      fwd_wr_data <= '0;
    end else begin
      fwd_wr_en <= wr_ok;
      fwd_rd_en <= rd_ok;
      if (wr_ok)
        fwd_wr_data <= wr_data;
    end
  end
endmodule

// File: rtl/lcdas_addr_status.sv
module lcdas_addr_status
  import lcdas_pkg::*;
#(
  parameter int IDX_W       = 2,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_mode,
  input  logic              rsel,
  input  logic              mem_access,
  input  logic              wr_en,
  input  logic              wr_is_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic              rd_is_addr,
  output logic [7:0]        status,
  output logic [IDX_W-1:0]  reg_index,
  output logic              standby,
  output logic              disp_on,
  output logic              hz,
  output logic              busy,
  output logic              fwd_wr_en,
  output logic              fwd_rd_en,
  output logic [7:0]        fwd_wr_data,
  output logic              so_oe
);
  localparam int LOW_BITS = BIT_HZ;

  ctrl_t ctrl;
  logic  addr_wr;

  lcdas_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .mem_access(mem_access), .busy(busy)
  );

  lcdas_access_gate u_gate (
    .clk(clk), .rst(rst), .serial_mode(serial_mode), .busy(busy),
    .wprot(ctrl.wprot), .wr_en(wr_en), .wr_is_addr(wr_is_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_is_addr(rd_is_addr),
    .addr_wr(addr_wr), .fwd_wr_en(fwd_wr_en), .fwd_rd_en(fwd_rd_en),
    .fwd_wr_data(fwd_wr_data)
  );

  lcdas_ctrl_bits #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .serial_mode(serial_mode), .rsel(rsel),
    .busy(busy), .addr_wr(addr_wr), .wr_data(wr_data),
    .ctrl(ctrl), .index(reg_index)
  );

  assign standby = ctrl.standby;
  assign disp_on = ctrl.disp_on;
  assign hz      = ctrl.hz;
  assign so_oe   = serial_mode & ~rst;

  assign status[BIT_BUSY]  = busy;
  assign status[BIT_STBY]  = ctrl.standby;
  assign status[BIT_DISP]  = ctrl.disp_on;
  assign status[BIT_WPROT] = ctrl.wprot & serial_mode;
  assign status[BIT_HZ]    = ctrl.hz;

  for (genvar g = 0; g < LOW_BITS; g++) begin : g_low
    if (g < IDX_W && g < IDX_MAX_W) begin : g_idx
      assign status[g] = reg_index[g];
    end else begin : g_zero
      assign status[g] = 1'b0;
    end
  end
endmodule

// File: rtl/lcdas_addr_status_chk.sv
module lcdas_addr_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       serial_mode,
  input logic       rsel,
  input logic       mem_access,
  input logic       wr_en,
  input logic       wr_is_addr,
  input logic [7:0] status,
  input logic       standby,
  input logic       busy,
  input logic       fwd_wr_en,
  input logic       fwd_rd_en,
  input logic       so_oe
);
  AST_BUSY_IN_RESET: assert property (@(posedge clk) rst |=> busy); // R1
  AST_BUSY_ON_ACCESS: assert property (@(posedge clk) disable iff (rst)
    mem_access |=> busy); // R3
  AST_NO_FWD_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!fwd_wr_en && !fwd_rd_en)); // R5
  AST_WPROT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (serial_mode && status[4] && wr_en && !wr_is_addr) |=> !fwd_wr_en); // R6
  AST_PAR_WPROT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !serial_mode |-> !status[4]); // R7
  AST_RSEL_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rsel) |=> !status[4]); // R8
  AST_NO_STBY_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !standby) |=> !standby); // R9
  AST_SO_OFF_IN_RESET: assert property (@(posedge clk)
    rst |-> !so_oe); // R10
  AST_BIT2_ZERO: assert property (@(posedge clk) disable iff (rst)
    !status[2]); // R2
endmodule

bind lcdas_addr_status lcdas_addr_status_chk u_chk (.*);

// File: tb/lcdas_addr_status_test.sv
module lcdas_addr_status_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serial_mode = 1'b0, rsel = 1'b0, mem_access = 1'b0;
  logic       wr_en = 1'b0, wr_is_addr = 1'b0, rd_en = 1'b0, rd_is_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status, fwd_wr_data;
  logic [1:0] reg_index;
  logic       standby, disp_on, hz, busy, fwd_wr_en, fwd_rd_en, so_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lcdas_addr_status uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_addr(logic [7:0] d);
    wr_en = 1; wr_is_addr = 1; wr_data = d;
    step();
    wr_en = 0; wr_is_addr = 0;
  endtask

  task automatic wr_other(logic [7:0] d);
    wr_en = 1; wr_is_addr = 0; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic pulse_mem();
    mem_access = 1;
    step();
    mem_access = 0;
  endtask

  task automatic settle();
    repeat (10) step();
  endtask

  task automatic t_reset();
    rst = 1; serial_mode = 1;
    repeat (3) step();
    chk("R1 busy in reset", busy, 1);
    chk("R1 status in reset", status, 8'h80);
    chk("R10 so_oe in reset", so_oe, 0);
    rst = 0;
    step();
    chk("R1 busy after release", busy, 0);
    chk("R10 so_oe serial", so_oe, 1);
    serial_mode = 0;
    #1 chk("R10 so_oe parallel", so_oe, 0);
  endtask

  task automatic t_layout();
    serial_mode = 1;
    wr_addr(8'h3F);
    chk("R2 layout serial", status, 8'h3B);
    wr_addr(8'h7E);
    chk("R2 layout standby", status, 8'h7A);
    chk("R2 index", reg_index, 2);
    chk("R2 hz", hz, 1);
    wr_addr(8'hC0);
    chk("R4 busy bit read only", status, 8'h40);
    wr_addr(8'h00);
  endtask

  task automatic t_busy();
    pulse_mem();
    chk("R3 busy sample 1", busy, 1);
    for (int i = 2; i <= 8; i++) begin
      step();
      chk("R3 busy held", busy, 1);
    end
    step();
    chk("R3 busy released", busy, 0);
    pulse_mem();
    repeat (4) step();
    pulse_mem();
    repeat (7) step();
    chk("R3 reload keeps busy", busy, 1);
    step();
    chk("R3 reload release", busy, 0);
  endtask

  task automatic t_fwd();
    serial_mode = 0;
    wr_other(8'hA5);
    chk("R11 fwd_wr_en pulse", fwd_wr_en, 1);
    chk("R11 fwd data", fwd_wr_data, 8'hA5);
    step();
    chk("R11 fwd_wr_en one cycle", fwd_wr_en, 0);
    rd_en = 1; rd_is_addr = 0;
    step();
    rd_en = 0;
    chk("R11 fwd_rd_en pulse", fwd_rd_en, 1);
    rd_en = 1; rd_is_addr = 1;
    step();
    rd_en = 0; rd_is_addr = 0;
    chk("R11 addr read not forwarded", fwd_rd_en, 0);
  endtask

  task automatic t_busy_gate();
    pulse_mem();
    wr_other(8'h11);
    chk("R5 write blocked while busy", fwd_wr_en, 0);
    rd_en = 1; rd_is_addr = 0;
    step();
    rd_en = 0;
    chk("R5 read blocked while busy", fwd_rd_en, 0);
    wr_addr(8'h20);
    chk("R5 addr write while busy", disp_on, 1);
    wr_addr(8'h40);
    chk("R9 standby set ignored while busy", standby, 0);
    settle();
    wr_addr(8'h40);
    chk("R9 standby set when idle", standby, 1);
    pulse_mem();
    wr_addr(8'h00);
    chk("R9 standby clear while busy", standby, 0);
    settle();
  endtask

  task automatic t_wprot();
    serial_mode = 1;
    wr_addr(8'h10);
    chk("R6 wprot set", status[4], 1);
    wr_other(8'h22);
    chk("R6 write dropped", fwd_wr_en, 0);
    wr_addr(8'h03);
    chk("R6 addr write accepted", status, 8'h03);
    wr_other(8'h33);
    chk("R6 write after unlock", fwd_wr_en, 1);
    wr_addr(8'h10);
    rsel = 1;
    step();
    rsel = 0;
    step();
    chk("R8 rsel fall clears", status[4], 0);
    rsel = 1;
    step();
    rsel = 0;
    wr_addr(8'h10);
    chk("R8 fall wins over write", status[4], 0);
  endtask

  task automatic t_parallel();
    serial_mode = 1;
    wr_addr(8'h10);
    serial_mode = 0;
    #1 chk("R7 parallel reads zero", status[4], 0);
    wr_other(8'h44);
    chk("R7 no protect in parallel", fwd_wr_en, 1);
    wr_addr(8'h10);
    chk("R7 parallel write ignored", status[4], 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step();
    t_reset();
    t_layout();
    t_busy();
    t_fwd();
    t_busy_gate();
    t_wprot();
    t_parallel();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule